// File: doc/BRIEF.md
# UART Register File with Receive Buffer

This block is the host-facing register file of a 16550-compatible serial port. It decodes single-byte reads and writes on a small address space and keeps the control registers. It holds the baud divisor and drives it to the baud generator. It owns the receive buffer that backs the data register. Received bytes enter through a valid/ready input. Bytes written to the data register leave on a one-cycle valid output. The bit-level shifter and baud timing sit outside this block.

The receive buffer runs at a depth of one byte until software enables the FIFO. It then holds up to `FIFO_DEPTH` bytes. Any change of the enable bit empties the buffer. In loopback mode, written bytes enter the receive buffer instead of the transmit output, and a write into a full buffer raises the overrun flag. The transmitter is modelled as always empty.

Top module: `uart_reg_file`

## Requirements
- R1: While LCR bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte, instead of data and IER. `divisor_o` equals {high, low}.
- R2: After reset the divisor is 0x0001. LCR, IER, MCR, scratch and the stored FCR are 0x00, the receive depth is 1, LSR reads 0x60 and IIR reads 0x01.
- R3: A write to offset 2 that changes bit 0 of the stored FCR empties the receive buffer. From the next cycle the depth is FIFO_DEPTH if the new bit 0 is 1, or 1 if it is 0.
- R4: A write to offset 2 with bit 0 clear stores 0x00 in FCR. With bit 0 set it stores the value AND 0xC9. In that case bit 1 empties the buffer and keeps depth FIFO_DEPTH. The stored value appears on `fifo_ctrl_o`.
- R5: A read of offset 5 returns bit 6 = 1, bit 5 = 1, bit 1 = the overrun flag, bit 0 = buffer not empty, and 0 in the other bits. The overrun flag is clear from the cycle after that read.
- R6: While MCR bit 4 is 1 (loopback), a data write pushes the byte into the receive buffer. If the buffer is full, the byte is dropped and the overrun flag is set. `tx_valid_o` stays low. `rx_ready_o` is 1, and each received byte is discarded.
- R7: Outside loopback, `rx_ready_o` is 1 exactly when the buffer is not full and no buffer-emptying FCR write is in progress. A byte is stored on each cycle with valid and ready both high.
- R8: Outside loopback, a data write raises `tx_valid_o` for one cycle in the cycle after the write, with `tx_data_o` equal to the written byte.
- R9: A data read returns the oldest buffered byte and removes it. When the buffer is empty it returns 0xFF and changes nothing.
- R10: Writes to offsets 5 and 6 have no effect, and offset 6 reads 0x00. Offset 7 is a plain read/write byte. LCR keeps all 8 bits, IER keeps bits 3:0 and MCR keeps bits 4:0. Offsets 8 and above read 0xFF.
- R11: A read of offset 2 returns 0xC1 while the stored FCR bit 0 is 1, and 0x01 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of the access |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive buffer accepts a byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| divisor_o | output | 16 | Baud divisor for the generator |
| fifo_ctrl_o | output | 8 | Stored FIFO control value |

## Verification
The bench builds the block with FIFO_DEPTH = 16 and ADDR_W = 4. This exercises the full sixteen-entry buffer, with its wrap and overflow edge, and makes the unused offsets 8 to 15 reachable. Random mixes of receive pushes, data reads and writes, status reads and loopback switching run against a queue model with the buffer enabled. This model covers overrun and back-pressure at both depths.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int unsigned OFF_DATA = 0;
  localparam int unsigned OFF_IER  = 1;
  localparam int unsigned OFF_FCR  = 2;
  localparam int unsigned OFF_LCR  = 3;
  localparam int unsigned OFF_MCR  = 4;
  localparam int unsigned OFF_LSR  = 5;
  localparam int unsigned OFF_MSR  = 6;
  localparam int unsigned OFF_SCR  = 7;

  localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;
  localparam logic [7:0] IER_KEEP_MASK = 8'h0F;
  localparam logic [7:0] MCR_KEEP_MASK = 8'h1F;
  localparam logic [7:0] RD_UNUSED     = 8'hFF;
  localparam int unsigned DLAB_BIT     = 7;
  localparam int unsigned LOOP_BIT     = 4;
  localparam logic [15:0] DIV_RESET    = 16'd1;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             deep_i,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [7:0]       data_i,
  input  logic             pop_i,
  output logic [7:0]       data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q, last_ptr;
  logic [CNT_W-1:0] cap;
  logic             do_push, do_pop;

  assign cap      = deep_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign last_ptr = deep_i ? PTR_W'(DEPTH - 1) : '0;
  assign full_o   = (count_o == cap);
  assign empty_o  = (count_o == '0);
  assign do_push  = push_i & ~full_o & ~flush_i;
  assign do_pop   = pop_i & ~empty_o & ~flush_i;
  assign data_o   = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == last_ptr) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == last_ptr) ? '0 : rptr_q + 1'b1;
      count_o <= count_o + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assert_no_push_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_flush_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  assert_count_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_oe_i,
  input  logic       clr_oe_i,
  input  logic       rx_avail_i,
  output logic [7:0] lsr_o
);
  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       oe_q <= 1'b0;
    else if (set_oe_i) oe_q <= 1'b1;
    else if (clr_oe_i) oe_q <= 1'b0;
  end

  // transmitter modelled as always empty
  assign lsr_o = {1'b0, 1'b1, 1'b1, 3'b000, oe_q, rx_avail_i};

  assert_oe_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_oe_i && !set_oe_i) |=> !lsr_o[1]);
  assert_oe_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_oe_i |=> lsr_o[1]);
endmodule

// File: rtl/uart_reg_file.sv
module uart_reg_file
  import uart_rf_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned ADDR_W     = 4,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic [15:0]       divisor_o,
  output logic [7:0]        fifo_ctrl_o
);
  logic [7:0] dll_q, dlh_q, ier_q, lcr_q, mcr_q, scr_q, fcr_q;
  logic       wr, rd, dlab, loop;
  logic       hit_data, hit_ier, hit_fcr, hit_lcr, hit_mcr, hit_lsr, hit_msr, hit_scr;
  logic       wr_data, flush, push, pop, oe_set, lsr_rd;
  logic [7:0] fifo_head, lsr, push_byte;
  logic [CNT_W-1:0] fifo_cnt;
  logic       fifo_full, fifo_empty;

  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;
  assign dlab = lcr_q[DLAB_BIT];
  assign loop = mcr_q[LOOP_BIT];

  assign hit_data = (addr_i == ADDR_W'(OFF_DATA));
  assign hit_ier  = (addr_i == ADDR_W'(OFF_IER));
  assign hit_fcr  = (addr_i == ADDR_W'(OFF_FCR));
  assign hit_lcr  = (addr_i == ADDR_W'(OFF_LCR));
  assign hit_mcr  = (addr_i == ADDR_W'(OFF_MCR));
  assign hit_lsr  = (addr_i == ADDR_W'(OFF_LSR));
  assign hit_msr  = (addr_i == ADDR_W'(OFF_MSR));
  assign hit_scr  = (addr_i == ADDR_W'(OFF_SCR));

  assign wr_data = wr & hit_data & ~dlab;
  // enable toggle or reset request while enabled
  assign flush   = wr & hit_fcr & ((wdata_i[0] ^ fcr_q[0]) | (wdata_i[0] & wdata_i[1]));
  assign push    = loop ? (wr_data & ~fifo_full) : (rx_valid_i & rx_ready_o);
  assign push_byte = loop ? wdata_i : rx_data_i;
  assign pop     = rd & hit_data & ~dlab & ~fifo_empty;
  assign oe_set  = loop & wr_data & fifo_full;
  assign lsr_rd  = rd & hit_lsr;

  assign rx_ready_o = loop | (~fifo_full & ~flush);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_q <= DIV_RESET[7:0];
      dlh_q <= DIV_RESET[15:8];
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
      fcr_q <= '0;
    end else if (wr) begin
      if (dlab && hit_data)     dll_q <= wdata_i;
      else if (dlab && hit_ier) dlh_q <= wdata_i;
      else if (hit_ier)         ier_q <= wdata_i & IER_KEEP_MASK;
      if (hit_fcr) fcr_q <= wdata_i[0] ? (wdata_i & FCR_KEEP_MASK) : 8'h00;
      if (hit_lcr) lcr_q <= wdata_i;
      if (hit_mcr) mcr_q <= wdata_i & MCR_KEEP_MASK;
      if (hit_scr) scr_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= wr_data & ~loop;
      if (wr_data & ~loop) tx_data_o <= wdata_i;
    end
  end

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .deep_i  (fcr_q[0]),
    .flush_i (flush),
    .push_i  (push),
    .data_i  (push_byte),
    .pop_i   (pop),
    .data_o  (fifo_head),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  uart_line_status i_line_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_oe_i   (oe_set),
    .clr_oe_i   (lsr_rd),
    .rx_avail_i (~fifo_empty),
    .lsr_o      (lsr)
  );

  always_comb begin
    rdata_o = RD_UNUSED;
    if (hit_data)     rdata_o = dlab ? dll_q : (fifo_empty ? RD_UNUSED : fifo_head);
    else if (hit_ier) rdata_o = dlab ? dlh_q : ier_q;
    else if (hit_fcr) rdata_o = {{2{fcr_q[0]}}, 6'b000001};
    else if (hit_lcr) rdata_o = lcr_q;
    else if (hit_mcr) rdata_o = mcr_q;
    else if (hit_lsr) rdata_o = lsr;
    else if (hit_msr) rdata_o = 8'h00;
    else if (hit_scr) rdata_o = scr_q;
  end

  assign divisor_o   = {dlh_q, dll_q};
  assign fifo_ctrl_o = fcr_q;

  assert_ready_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop && fifo_full) |-> !rx_ready_o);
  assert_tx_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && loop) |=> !tx_valid_o);
  assert_tx_echo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !loop) |=> (tx_valid_o && tx_data_o == $past(wdata_i)));
  assert_empty_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_data && !dlab && fifo_empty) |-> rdata_o == RD_UNUSED);
endmodule

// File: tb/test_uart_reg_file.sv
module test_uart_reg_file;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0, rdata;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready, tx_valid;
  logic [7:0]    tx_data, fifo_ctrl;
  logic [15:0]   divisor;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] q[$];
  int  cap = 1;
  bit  oe = 1'b0, loop = 1'b0;

  always #10 clk = ~clk;

  uart_reg_file #(.FIFO_DEPTH(DEPTH), .ADDR_W(AW)) i_uart_reg_file (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_ready_o(rx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .divisor_o(divisor), .fifo_ctrl_o(fifo_ctrl)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_lsr();
    return 8'h60 | (int'(oe) << 1) | int'(q.size() != 0);
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = 8'(d);
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, output int r);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    #2 r = int'(rdata);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    int r;
    rd(a, r);
    check(tag, r, exp);
  endtask

  // rx push with ready check against model
  task automatic rx_push(string tag, int d);
    bit exp_rdy;
    exp_rdy = loop || (q.size() < cap);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'(d);
    #2 check(tag, int'(rx_ready), int'(exp_rdy));
    @(posedge clk); #1;
    rx_valid = 1'b0;
    if (!loop && exp_rdy) q.push_back(8'(d));
  endtask

  task automatic data_wr(string tag, int d);
    wr(0, d);
    if (loop) begin
      if (q.size() < cap) q.push_back(8'(d)); else oe = 1'b1;
      check(tag, int'(tx_valid), 0);
    end else begin
      check(tag, int'({tx_valid, tx_data}), 'h100 | d);
      @(posedge clk); #1;
      check(tag, int'(tx_valid), 0);
    end
  endtask

  task automatic data_rd(string tag);
    int exp;
    exp = (q.size() != 0) ? int'(q.pop_front()) : 'hFF;
    rd_chk(tag, 0, exp);
  endtask

  task automatic lsr_rd(string tag);
    rd_chk(tag, 5, exp_lsr());
    oe = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset state
    check("R2 divisor", int'(divisor), 1);
    check("R2 fcr", int'(fifo_ctrl), 0);
    rd_chk("R2 lcr", 3, 0);
    rd_chk("R2 ier", 1, 0);
    rd_chk("R2 mcr", 4, 0);
    rd_chk("R2 scr", 7, 0);
    rd_chk("R2 lsr", 5, 'h60);
    rd_chk("R11 iir off", 2, 'h01);

    // R1 divisor latch
    wr(3, 'h80);
    wr(0, 'h34);
    wr(1, 'h12);
    check("R1 divisor", int'(divisor), 'h1234);
    rd_chk("R1 dll", 0, 'h34);
    rd_chk("R1 dlh", 1, 'h12);
    rd_chk("R10 lcr 8b", 3, 'h80);
    wr(3, 'h03);
    rd_chk("R10 lcr", 3, 'h03);
    wr(1, 'hFF);
    rd_chk("R10 ier mask", 1, 'h0F);
    check("R1 divisor kept", int'(divisor), 'h1234);
    data_rd("R9 empty read");
    lsr_rd("R9 empty unchanged");

    // R7 depth 1 back-pressure
    rx_push("R7 accept", 'hA5);
    rx_push("R7 full", 'h5A);
    lsr_rd("R5 rxrdy");
    data_rd("R9 pop");
    data_rd("R9 empty again");

    // R3 enable flushes, depth 16
    rx_push("R7 accept", 'h77);
    wr(2, 'h01); q.delete(); cap = DEPTH;
    lsr_rd("R3 flushed");
    check("R4 fcr en", int'(fifo_ctrl), 'h01);
    rd_chk("R11 iir on", 2, 'hC1);
    wr(2, 'hFF); q.delete();
    check("R4 fcr mask", int'(fifo_ctrl), 'hC9);
    for (int i = 0; i < DEPTH; i++) rx_push("R3 fill", 'h10 + i);
    rx_push("R7 full16", 'hEE);
    data_rd("R9 order");
    data_rd("R9 order");
    wr(2, 'h03); q.delete();
    check("R4 fcr bit1", int'(fifo_ctrl), 'h01);
    lsr_rd("R4 reset flush");
    for (int i = 0; i < 3; i++) rx_push("R4 depth kept", 'h40 + i);
    wr(2, 'h00); q.delete(); cap = 1;
    check("R4 fcr off", int'(fifo_ctrl), 0);
    lsr_rd("R3 disable flush");
    rx_push("R3 depth1", 'h01);
    rx_push("R3 depth1 full", 'h02);
    data_rd("R3 depth1 pop");

    // R6 loopback
    wr(4, 'h10); loop = 1'b1;
    rd_chk("R10 mcr", 4, 'h10);
    data_wr("R6 lb push", 'h11);
    data_wr("R6 lb overrun", 'h22);
    lsr_rd("R6 oe set");
    lsr_rd("R5 oe cleared");
    rx_push("R6 rx discard", 'h99);
    data_rd("R6 lb data");
    lsr_rd("R6 discard empty");
    wr(4, 'h00); loop = 1'b0;

    // R8 transmit
    data_wr("R8 tx", 'h5A);
    data_wr("R8 tx", 'hC3);

    // R10 misc
    wr(5, 'hFF);
    lsr_rd("R10 lsr wr ignored");
    wr(6, 'hFF);
    rd_chk("R10 msr", 6, 'h00);
    wr(7, 'hA7);
    rd_chk("R10 scr", 7, 'hA7);
    rd_chk("R10 unused", 9, 'hFF);
    rd_chk("R10 unused", 15, 'hFF);
    wr(4, 'hFF);
    rd_chk("R10 mcr mask", 4, 'h1F);
    wr(4, 'h00);

    // random mix, buffer enabled
    wr(2, 'h01); q.delete(); cap = DEPTH;
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3)       rx_push("R7 rand push", $urandom_range(0, 255));
      else if (op < 5)  data_wr(loop ? "R6 rand lb" : "R8 rand tx", $urandom_range(0, 255));
      else if (op < 7)  data_rd("R9 rand read");
      else if (op < 9)  lsr_rd("R5 rand lsr");
      else begin
        loop = ($urandom_range(0, 1) == 1);
        wr(4, loop ? 'h10 : 'h00);
      end
    end
    done = 1'b1;
    finish_run();
  end
endmodule